// File: doc/BRIEF.md
# ADC Parallel Readout and Sync Control

This block sits between the decimation filter of a sigma-delta converter and its parallel output pins. The filter hands over each finished 16-bit word with a one-cycle strobe. The block keeps that word pending and moves it into the output word register on a fixed word boundary. Before each boundary it raises a data-ready signal for two clocks. The boundary repeats every 16 or 32 master clocks, set by the decimation select input.

An external reader selects the bus with active-low chip-select and read. Both are sampled on the rising edge of the master clock. The bus is driven only while both are low. The pad-level tri-state buffer is controlled by `bus_oe`, and `bus_data` is held at zero whenever the bus is released.

A synchronisation input restarts the pipeline. While it is sampled high, data-ready is held high, the word phase is held at zero and filter strobes are discarded. After it is released, data-ready stays high for a fixed settling interval. A change of the decimation select restarts the settling interval in the same way.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released until the first pulse, `drdy` is 0, `bus_oe` is 0 and `bus_data` is 0.
- R2: In steady operation, `drdy` falls once every 16 clocks when `dec_sel` = 0, and once every 32 clocks when `dec_sel` = 1.
- R3: Each steady-state `drdy` pulse is high for exactly two clocks. The output word register changes only on the clock edge where `drdy` falls.
- R4: A word presented on `word_in` with `word_stb` high appears on the bus at the next falling edge of `drdy`. With no new strobe, the same word is presented again at later boundaries.
- R5: One clock after an edge that samples `cs_n` = 0 and `rd_n` = 0, `bus_oe` is 1 and `bus_data` carries the output word. One clock after an edge that samples either of them high, `bus_oe` is 0 and `bus_data` is 0.
- R6: One clock after an edge that samples `sync_in` high, `drdy` is 1. It stays 1 while `sync_in` remains high.
- R7: After `sync_in` is released, `drdy` stays high and falls on the 2049th rising edge that samples `sync_in` low.
- R8: A `word_stb` sampled together with `sync_in` high is ignored. After settling, the word captured before the sync is presented.
- R9: A change of `dec_sel` restarts settling. `drdy` is high from the change edge and falls on the 2049th edge after it. The new decimation period is used from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | One-cycle strobe from the filter marking a finished word |
| word_in | input | 16 | Word from the filter, valid with `word_stb` |
| dec_sel | input | 1 | Decimation select: 0 = 16 clocks per word, 1 = 32 clocks per word |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| sync_in | input | 1 | Active-high pipeline restart |
| bus_data | output | 16 | Parallel word, zero while the bus is released |
| bus_oe | output | 1 | Output enable for the pad tri-state buffer |
| drdy | output | 1 | Data-ready, high before each new word and during settling |

## Verification
A wrong phase counter shows up within one word period: the spacing or width of the `drdy` pulses changes, or the new word lands on an edge other than the falling one. A wrong settling counter moves the end of the long `drdy` high after a sync or mode change by at least one clock, and the bench counts those edges exactly. A pending-word register that is loaded during sync, or loaded at the wrong time, puts a wrong value on the bus at the first boundary after settling. A wrong read gate shows on `bus_oe` and `bus_data` one clock after chip-select or read moves.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic {
    DEC_SHORT = 1'b0,
    DEC_LONG  = 1'b1
  } dec_e;
endpackage

// File: rtl/adc_rd_phase.sv
module adc_rd_phase #(
  parameter int SHORT_N = 16,
  parameter int LONG_N  = 32,
  parameter int PULSE   = 2,
  parameter int PH_W    = $clog2(LONG_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            long_sel,
  output logic [PH_W-1:0] ph_q,
  output logic            wrap_next,
  output logic            pulse_next
);
  localparam logic [PH_W-1:0] SHORT_LAST = PH_W'(SHORT_N - 1);
  localparam logic [PH_W-1:0] LONG_LAST  = PH_W'(LONG_N - 1);
  localparam logic [PH_W-1:0] PULSE_OFS  = PH_W'(PULSE - 1);

  logic [PH_W-1:0] last_v;
  logic [PH_W-1:0] pstart_v;
  logic [PH_W-1:0] nph;

  always_comb begin
    last_v     = long_sel ? LONG_LAST : SHORT_LAST;
    pstart_v   = last_v - PULSE_OFS;
    wrap_next  = !restart && (ph_q == last_v);
    if (restart || ph_q == last_v) nph = '0;
    else                           nph = ph_q + 1'b1;
    pulse_next = !restart && (nph >= pstart_v);
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= nph;
  end

  // R2: the phase never leaves the active period
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    ph_q <= (long_sel ? LONG_LAST : SHORT_LAST));
endmodule

// File: rtl/adc_rd_settle.sv
module adc_rd_settle #(
  parameter int SETTLE = 2049,
  parameter int CW     = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt_q,
  output logic          busy_next
);
  localparam logic [CW-1:0] LOAD_V = CW'(SETTLE);

  logic [CW-1:0] cnt_next;

  always_comb begin
    if (restart)           cnt_next = LOAD_V;
    else if (cnt_q != '0)  cnt_next = cnt_q - 1'b1;
    else                   cnt_next = '0;
    busy_next = (cnt_next != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

  // R7: the count drains by one per clock when not restarted
  p_settle_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (!restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_rd_bus.sv
module adc_rd_bus #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] cap_word,
  input  logic         load_en,
  input  logic         cs_n,
  input  logic         rd_n,
  output logic [W-1:0] word_q,
  output logic [W-1:0] bus_data,
  output logic         bus_oe
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      word_q <= '0;
      bus_oe <= 1'b0;
    end else begin
      if (cap_en)  pend_q <= cap_word;
      if (load_en) word_q <= pend_q;
      bus_oe <= !cs_n && !rd_n;
    end
  end

  assign bus_data = bus_oe ? word_q : '0;

  // R5: a deselected or idle reader releases the bus on the next clock
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> (!bus_oe && bus_data == '0));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int WORD_W      = 16,
  parameter int SHORT_N     = 16,
  parameter int LONG_N      = 32,
  parameter int DRDY_PULSE  = 2,
  parameter int SETTLE_CLKS = 2049
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              dec_sel,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sync_in,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              drdy
);
  import adc_rd_pkg::*;

  localparam int PH_W = $clog2(LONG_N);
  localparam int CW   = $clog2(SETTLE_CLKS + 1);

  dec_e              mode_q;
  logic              mode_chg;
  logic              restart;
  logic [PH_W-1:0]   ph_q;
  logic              wrap_next;
  logic              pulse_next;
  logic [CW-1:0]     cnt_q;
  logic              busy_next;
  logic [WORD_W-1:0] word_q;

  assign mode_chg = (dec_e'(dec_sel) != mode_q);
  assign restart  = sync_in || mode_chg;

  adc_rd_phase #(
    .SHORT_N(SHORT_N), .LONG_N(LONG_N), .PULSE(DRDY_PULSE), .PH_W(PH_W)
  ) u_phase (
    .clk(clk), .rst(rst), .restart(restart),
    .long_sel(mode_q == DEC_LONG),
    .ph_q(ph_q), .wrap_next(wrap_next), .pulse_next(pulse_next)
  );

  adc_rd_settle #(.SETTLE(SETTLE_CLKS), .CW(CW)) u_settle (
    .clk(clk), .rst(rst), .restart(restart),
    .cnt_q(cnt_q), .busy_next(busy_next)
  );

  adc_rd_bus #(.W(WORD_W)) u_bus (
    .clk(clk), .rst(rst),
    .cap_en(word_stb && !sync_in), .cap_word(word_in),
    .load_en(wrap_next && !busy_next),
    .cs_n(cs_n), .rd_n(rd_n),
    .word_q(word_q), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= DEC_SHORT;
      drdy   <= 1'b0;
    end else begin
      mode_q <= dec_e'(dec_sel);
      drdy   <= restart || busy_next || pulse_next;
    end
  end

  // R6: a sampled sync forces data-ready high
  p_sync_drdy_r6: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> drdy);
  // R7: data-ready covers the whole settling interval
  p_settle_drdy_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> drdy);
  // R3: the output word moves only where data-ready falls
  p_update_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> $fell(drdy));
  // R3: every fall follows at least two high clocks
  p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy) |-> $past(drdy, 2));
  // R2: the phase sits at zero right after a restart
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ph_q == '0));
endmodule

// File: tb/tb_adc_readout_ctrl.sv
module tb_adc_readout_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_stb = 1'b0;
  logic [15:0] word_in = '0;
  logic        dec_sel = 1'b0;
  logic        cs_n = 1'b0;
  logic        rd_n = 1'b0;
  logic        sync_in = 1'b0;
  logic [15:0] bus_data;
  logic        bus_oe;
  logic        drdy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int fall_cnt = 0;
  int per = 0;
  int hi_n = 0;
  int exp_n = 16;
  bit mon_en = 1'b0;
  bit have_ref = 1'b0;
  bit drdy_prev = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] last_w = '0;

  adc_readout_ctrl dut (
    .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
    .dec_sel(dec_sel), .cs_n(cs_n), .rd_n(rd_n), .sync_in(sync_in),
    .bus_data(bus_data), .bus_oe(bus_oe), .drdy(drdy)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      per++;
      if (drdy) hi_n++;
      if (drdy_prev && !drdy) begin
        if (mon_en) begin
          chk(hi_n == 2, "R3 pulse width", hi_n, 2);
          if (have_ref) chk(per == exp_n, "R2 period", per, exp_n);
          if (exp_q.size() == 0) chk(1'b0, "R4 no expected word", 0, 0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(bus_oe && bus_data == e, "R4 word on bus", int'(bus_data), int'(e));
          end
        end
        have_ref = mon_en;
        per = 0;
        hi_n = 0;
        fall_cnt++;
      end
      drdy_prev = drdy;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_fall();
    int n;
    n = fall_cnt;
    while (fall_cnt == n) @(negedge clk);
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!drdy) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    word_in = w;
    word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    exp_q.push_back(w);
    last_w = w;
    wait_fall();
  endtask

  initial begin
    bit held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(drdy == 1'b0, "R1 drdy in reset", drdy, 0);
    chk(bus_oe == 1'b0, "R1 oe in reset", bus_oe, 0);
    chk(bus_data == 16'h0, "R1 bus in reset", bus_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(drdy == 1'b0 && bus_data == 16'h0, "R1 after release", drdy, 0);

    // R2/R3/R4 steady decimate-by-16
    wait_fall();
    mon_en = 1'b1;
    for (int i = 0; i < 6; i++) send_word(16'h1000 + 16'(i * 16'h0111));
    // R4 repeat with no new strobe
    exp_q.push_back(last_w);
    wait_fall();

    // R5 bus gating
    mon_en = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    chk(!bus_oe && bus_data == 16'h0, "R5 release on cs_n", bus_oe, 0);
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    chk(!bus_oe && bus_data == 16'h0, "R5 release on rd_n", bus_oe, 0);
    rd_n = 1'b0;
    @(negedge clk);
    chk(bus_oe && bus_data == last_w, "R5 drive word", int'(bus_data), int'(last_w));

    // R6/R7/R8 sync
    sync_in = 1'b1;
    word_in = 16'hDEAD;
    word_stb = 1'b1;
    @(negedge clk);
    chk(drdy == 1'b1, "R6 drdy on sync", drdy, 1);
    @(negedge clk);
    @(negedge clk);
    chk(drdy == 1'b1, "R6 drdy held", drdy, 1);
    sync_in = 1'b0;
    word_stb = 1'b0;
    held = 1'b1;
    for (int k = 0; k < 2048; k++) begin
      @(negedge clk);
      if (!drdy) held = 1'b0;
    end
    chk(held, "R7 high through settling", held, 1);
    @(negedge clk);
    chk(drdy == 1'b0, "R7 fall on 2049th edge", drdy, 0);
    exp_q.push_back(last_w);   // R8: DEAD ignored
    wait_rise();
    mon_en = 1'b1;
    wait_fall();
    send_word(16'hA5C3);

    // R9 mode change
    mon_en = 1'b0;
    dec_sel = 1'b1;
    held = 1'b1;
    for (int k = 0; k < 2049; k++) begin
      @(negedge clk);
      if (!drdy) held = 1'b0;
    end
    chk(held, "R9 high after mode change", held, 1);
    @(negedge clk);
    chk(drdy == 1'b0, "R9 fall on 2049th edge", drdy, 0);
    exp_n = 32;
    exp_q.push_back(last_w);
    wait_rise();
    mon_en = 1'b1;
    wait_fall();
    for (int i = 0; i < 4; i++) send_word(16'h7F00 - 16'(i * 16'h0203));
    mon_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule